// File: doc/BRIEF.md
# Secondary Core Launch Controller

This block lets a boot processor hold secondary cores in a halted state and release them one at a time. Software talks to it through two adjacent write-only registers: a parameter register that holds a start address, and a command register whose word names a target core and an operation. One operation copies the parameter register into the named core's stored start address. The other releases the named core so that it begins fetching from that address.

Each core has its own small state machine with three named states. HALTED is the state after reset for every core except core 0. A release command takes a HALTED core through the transition HALTED→LAUNCH. LAUNCH lasts exactly one cycle and then always moves on through the transition LAUNCH→RUNNING. RUNNING persists until reset. Core 0 comes out of reset directly in RUNNING. A core's run enable is high in LAUNCH and RUNNING. Its start pulse is high only in LAUNCH. Its start-address output shows the stored address while the core is HALTED, and shows the value captured on the HALTED→LAUNCH transition from then on.

The intended software sequence is: write the address into the parameter register, issue the load command for the core, then issue the release command for it. The number of cores, the address width and the register base are parameters.

Top module: `cpu_boot_ctrl`

## Requirements
- R1: After reset, `core_run` has only bit 0 set, `core_start_pulse` is all zero, and every start address reads zero.
- R2: A write to address BASE+1 loads the parameter register with the low AW data bits. Writes to any address other than BASE and BASE+1 change nothing.
- R3: A write to address BASE whose bits 7:0 equal 0x04 copies the parameter register into the stored start address of the core whose index is in bits 15:8. A halted core shows the new value on its `core_start_pc` slice after the clock edge that captures the write.
- R4: A write to BASE with opcode 0x02 in bits 7:0 releases the halted core named in bits 15:8. Its `core_run` bit and its `core_start_pulse` bit both go high after the edge that captures the write.
- R5: `core_start_pulse` for a core is high for exactly one cycle per release. A release command naming a core that is already running produces no pulse.
- R6: While a core runs, its `core_start_pc` slice holds steady, even when a load command names that core.
- R7: A command whose core index is N_CPU or more, or whose opcode is neither 0x04 nor 0x02, has no effect on any output.
- R8: Once a core's run bit is high, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | RAW | Register address (command at BASE, parameter at BASE+1) |
| reg_wr_data | input | DW | Register write data |
| core_run | output | N_CPU | Per-core run enable |
| core_start_pulse | output | N_CPU | One-cycle start pulse per core on release |
| core_start_pc | output | N_CPU*AW | Per-core start address, core i at bits i*AW +: AW |

## Verification
The hardest situation to reach from the ports is a load command aimed at a core that is already running. In that case the stored address changes but the output must not. The stimulus reaches it by first releasing a core with one address, then writing a different address into the parameter register, then loading it into that running core. After that the bench checks that the core's address slice still shows the original value. Release commands repeated on running cores, and commands with out-of-range indices and unknown opcodes, are interleaved in the same sequence. A pulse on the wrong core, or a change on any address slice, would therefore show up.

// File: rtl/cpu_boot_pkg.sv
package cpu_boot_pkg;

    typedef enum logic [1:0] {
        SLOT_HALTED  = 2'd0,
        SLOT_LAUNCH  = 2'd1,
        SLOT_RUNNING = 2'd2
    } slot_state_t;

    localparam logic [7:0] OP_LOAD_PC = 8'h04;
    localparam logic [7:0] OP_RELEASE = 8'h02;

endpackage

// File: rtl/boot_cmd_decode.sv
module boot_cmd_decode
    import cpu_boot_pkg::*;
#(
    parameter int                N_CPU = 4,
    parameter int                AW    = 32,
    parameter int                DW    = 32,
    parameter int                RAW   = 12,
    parameter logic [RAW-1:0]    BASE  = 12'h200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RAW-1:0]   wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [AW-1:0]    param_q,
    output logic [N_CPU-1:0] load_stb,
    output logic [N_CPU-1:0] release_stb
);

    localparam logic [RAW-1:0] CMD_ADDR   = BASE;
    localparam logic [RAW-1:0] PARAM_ADDR = BASE + RAW'(1);

    logic       cmd_hit;
    logic       param_hit;
    logic [7:0] opcode;
    logic [7:0] target;

    assign cmd_hit   = wr_en && (wr_addr == CMD_ADDR);
    assign param_hit = wr_en && (wr_addr == PARAM_ADDR);
    assign opcode    = wr_data[7:0];
    assign target    = wr_data[15:8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            param_q <= '0;
        end else if (param_hit) begin
            param_q <= wr_data[AW-1:0];
        end
    end

    for (genvar i = 0; i < N_CPU; i++) begin : g_strobe
        localparam logic [7:0] MY_IDX = 8'(i);
        assign load_stb[i]    = cmd_hit && (target == MY_IDX) && (opcode == OP_LOAD_PC);
        assign release_stb[i] = cmd_hit && (target == MY_IDX) && (opcode == OP_RELEASE);
    end

    // R2: the parameter register only moves on a write to its own address
    p_param_only_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !param_hit |=> $stable(param_q));

endmodule

// File: rtl/boot_slot.sv
module boot_slot
    import cpu_boot_pkg::*;
#(
    parameter int AW            = 32,
    parameter bit START_RUNNING = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_stb,
    input  logic          release_stb,
    input  logic [AW-1:0] param_q,
    output logic          run,
    output logic          start_pulse,
    output logic [AW-1:0] start_pc
);

    localparam slot_state_t RESET_STATE = START_RUNNING ? SLOT_RUNNING : SLOT_HALTED;

    slot_state_t   state_q;
    slot_state_t   state_d;
    logic [AW-1:0] stored_pc;
    logic [AW-1:0] launch_pc;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_HALTED:  if (release_stb) state_d = SLOT_LAUNCH;
            SLOT_LAUNCH:  state_d = SLOT_RUNNING;
            SLOT_RUNNING: state_d = SLOT_RUNNING;
            default:      state_d = SLOT_HALTED;
        endcase
    end

    // State register and address storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= RESET_STATE;
            stored_pc <= '0;
            launch_pc <= '0;
        end else begin
            state_q <= state_d;
            if (load_stb) begin
                stored_pc <= param_q;
            end
            if (state_q == SLOT_HALTED && state_d == SLOT_LAUNCH) begin
                launch_pc <= stored_pc;
            end
        end
    end

    // Outputs
    always_comb begin
        run         = 1'b0;
        start_pulse = 1'b0;
        start_pc    = launch_pc;
        unique case (state_q)
            SLOT_HALTED: begin
                start_pc = stored_pc;
            end
            SLOT_LAUNCH: begin
                run         = 1'b1;
                start_pulse = 1'b1;
            end
            SLOT_RUNNING: begin
                run = 1'b1;
            end
            default: begin
                run = 1'b0;
            end
        endcase
    end

    // R5: a start pulse never lasts two cycles
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // R4: run rises only together with a start pulse
    p_rise_with_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> start_pulse);

    // R5: a pulse only accompanies a fresh release
    p_pulse_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $rose(run));

    // R8: run is sticky
    p_run_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    // R6: address output frozen once running
    p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(start_pc));

endmodule

// File: rtl/cpu_boot_ctrl.sv
module cpu_boot_ctrl
    import cpu_boot_pkg::*;
#(
    parameter int             N_CPU = 4,
    parameter int             AW    = 32,
    parameter int             DW    = 32,
    parameter int             RAW   = 12,
    parameter logic [RAW-1:0] BASE  = 12'h200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [RAW-1:0]      reg_wr_addr,
    input  logic [DW-1:0]       reg_wr_data,
    output logic [N_CPU-1:0]    core_run,
    output logic [N_CPU-1:0]    core_start_pulse,
    output logic [N_CPU*AW-1:0] core_start_pc
);

    logic [AW-1:0]    param_q;
    logic [N_CPU-1:0] load_stb;
    logic [N_CPU-1:0] release_stb;

    boot_cmd_decode #(
        .N_CPU (N_CPU),
        .AW    (AW),
        .DW    (DW),
        .RAW   (RAW),
        .BASE  (BASE)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_addr     (reg_wr_addr),
        .wr_data     (reg_wr_data),
        .param_q     (param_q),
        .load_stb    (load_stb),
        .release_stb (release_stb)
    );

    for (genvar i = 0; i < N_CPU; i++) begin : g_slot
        boot_slot #(
            .AW            (AW),
            .START_RUNNING (i == 0)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_stb    (load_stb[i]),
            .release_stb (release_stb[i]),
            .param_q     (param_q),
            .run         (core_run[i]),
            .start_pulse (core_start_pulse[i]),
            .start_pc    (core_start_pc[i*AW +: AW])
        );
    end

    // R7: no write, no pulse on any core
    p_no_pulse_without_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> (core_start_pulse == '0));

endmodule

// File: tb/cpu_boot_ctrl_tb.sv
module cpu_boot_ctrl_tb;

    localparam int             N_CPU = 4;
    localparam int             AW    = 32;
    localparam int             DW    = 32;
    localparam int             RAW   = 12;
    localparam logic [RAW-1:0] BASE  = 12'h200;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                reg_wr_en = 1'b0;
    logic [RAW-1:0]      reg_wr_addr = '0;
    logic [DW-1:0]       reg_wr_data = '0;
    logic [N_CPU-1:0]    core_run;
    logic [N_CPU-1:0]    core_start_pulse;
    logic [N_CPU*AW-1:0] core_start_pc;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    cpu_boot_ctrl #(
        .N_CPU (N_CPU), .AW (AW), .DW (DW), .RAW (RAW), .BASE (BASE)
    ) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_wr_en        (reg_wr_en),
        .reg_wr_addr      (reg_wr_addr),
        .reg_wr_data      (reg_wr_data),
        .core_run         (core_run),
        .core_start_pulse (core_start_pulse),
        .core_start_pc    (core_start_pc)
    );

    // sel: 1 = parameter register (BASE+1), 0 = command register (BASE)
    typedef struct packed {
        logic        sel;
        logic [31:0] data;
        logic [3:0]  exp_run;
        logic [3:0]  exp_pulse;
        logic [1:0]  chk;
        logic [31:0] exp_pc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000_1000, 4'b0001, 4'b0000, 2'd1, 32'h0000_0000, 4'd2}, // R2
        '{1'b0, 32'h0000_0104, 4'b0001, 4'b0000, 2'd1, 32'h0000_1000, 4'd3}, // R3
        '{1'b0, 32'h0000_0102, 4'b0011, 4'b0010, 2'd1, 32'h0000_1000, 4'd4}, // R4
        '{1'b1, 32'h0000_2000, 4'b0011, 4'b0000, 2'd1, 32'h0000_1000, 4'd6}, // R6
        '{1'b0, 32'h0000_0104, 4'b0011, 4'b0000, 2'd1, 32'h0000_1000, 4'd6}, // R6
        '{1'b0, 32'h0000_0102, 4'b0011, 4'b0000, 2'd1, 32'h0000_1000, 4'd5}, // R5
        '{1'b0, 32'h0000_0404, 4'b0011, 4'b0000, 2'd3, 32'h0000_0000, 4'd7}, // R7
        '{1'b0, 32'h0000_0305, 4'b0011, 4'b0000, 2'd3, 32'h0000_0000, 4'd7}, // R7
        '{1'b0, 32'h0000_0301, 4'b0011, 4'b0000, 2'd3, 32'h0000_0000, 4'd7}, // R7
        '{1'b0, 32'h0000_0304, 4'b0011, 4'b0000, 2'd3, 32'h0000_2000, 4'd3}, // R3
        '{1'b0, 32'h0000_0302, 4'b1011, 4'b1000, 2'd3, 32'h0000_2000, 4'd4}, // R4
        '{1'b0, 32'h0000_0002, 4'b1011, 4'b0000, 2'd0, 32'h0000_0000, 4'd5}, // R5
        '{1'b0, 32'h0000_FF02, 4'b1011, 4'b0000, 2'd2, 32'h0000_0000, 4'd7}, // R7
        '{1'b1, 32'h000A_BCD0, 4'b1011, 4'b0000, 2'd2, 32'h0000_0000, 4'd2}, // R2
        '{1'b0, 32'h0000_0204, 4'b1011, 4'b0000, 2'd2, 32'h000A_BCD0, 4'd3}, // R3
        '{1'b0, 32'h0000_0202, 4'b1111, 4'b0100, 2'd2, 32'h000A_BCD0, 4'd4}, // R4
        '{1'b0, 32'h0000_0304, 4'b1111, 4'b0000, 2'd3, 32'h0000_2000, 4'd6}  // R6
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one write, let one edge capture it, then sample at the next negedge
    task automatic write_reg(input logic [RAW-1:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_addr = addr;
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_reset_state();
        check("R1", "run", 32'(core_run), 32'h1);
        check("R1", "pulse", 32'(core_start_pulse), 32'h0);
        for (int c = 0; c < N_CPU; c++)
            check("R1", "pc", core_start_pc[c*AW +: AW], 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        do_reset();
        check_reset_state();

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[v].req);
            write_reg(BASE + RAW'(VECS[v].sel), VECS[v].data);
            check(tag, $sformatf("vec%0d run", v), 32'(core_run), 32'(VECS[v].exp_run));
            check(tag, $sformatf("vec%0d pulse", v), 32'(core_start_pulse), 32'(VECS[v].exp_pulse));
            check(tag, $sformatf("vec%0d pc", v),
                  core_start_pc[int'(VECS[v].chk)*AW +: AW], VECS[v].exp_pc);
        end

        // R1: second reset restores the initial state
        do_reset();
        check_reset_state();

        // R2: stray addresses around the register pair are ignored
        write_reg(BASE + RAW'(1), 32'h0000_0077);
        write_reg(BASE + RAW'(2), 32'h0000_0104);
        write_reg(BASE - RAW'(1), 32'h0000_0104);
        check("R2", "stray addr pc1", core_start_pc[1*AW +: AW], 32'h0);
        check("R2", "stray addr run", 32'(core_run), 32'h1);

        // R5, R8: pulse lasts one cycle, run stays high
        write_reg(BASE, 32'h0000_0102);
        check("R5", "pulse first cycle", 32'(core_start_pulse), 32'h2);
        @(negedge clk);
        check("R5", "pulse second cycle", 32'(core_start_pulse), 32'h0);
        check("R8", "run after pulse", 32'(core_run), 32'h3);
        repeat (5) @(negedge clk);
        check("R8", "run later", 32'(core_run), 32'h3);
        check("R6", "pc1 unloaded", core_start_pc[1*AW +: AW], 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule